// File: doc/BRIEF.md
# Scheduled Bit-Flip Fault Injector

This block runs a fault-injection campaign against a bank of registers that sits outside it. Before a campaign, a short list of injection instants is written into a small schedule memory. Two pseudo-random generators are also seeded: one selects the target register and the other selects the bit inside it. A start pulse zeroes a free-running cycle counter. Each time that counter reaches the next scheduled instant, the block emits a one-cycle strobe together with a register address and a one-hot inversion mask. The logic around the block flips that bit in the selected register.

After each strobe, the error checker of the design under test gets a fixed window in which to report what it saw. It can report that the error was corrected, that it was detected only, or that it was not detected. If it reports nothing inside the window, the injection counts as undetected. The block keeps a campaign total and one counter per outcome, both for the whole bank and for each register. These counters stay readable after the schedule runs out and a done flag rises. They are zeroed only by a synchronous clear. Because each generator steps once per injection, the same seeds and the same schedule reproduce the same sequence of targets.

Top module: `seu_injector`

## Requirements
- R1: After reset, `inj_stb`, `inj_mask`, `done` and `busy` are low, and every readable counter reads zero.
- R2: A `seed_we` pulse loads `seed_reg` into the register-select generator and `seed_bit` into the bit-select generator. A seed of zero is replaced by 1. Reset loads 1 into both generators.
- R3: The cycle after the `start` pulse is campaign cycle 0. For a schedule entry with time T (T >= 1), `inj_stb` is high in exactly campaign cycle T+1. Each entry must be at least `WIN`+1 later than the entry before it.
- R4: During a strobe, `inj_addr` equals the register-select value modulo `NUM_REGS`, and `inj_mask` equals 1 shifted left by (the bit-select value modulo `REG_W`). Both values are taken before the generators step. The mask has exactly one bit set during a strobe and is zero otherwise, and each strobe lasts one cycle.
- R5: Each generator is a 16-bit shift register that shifts toward the MSB. The new LSB is the XOR of bits 15, 14, 12 and 3. Each generator steps exactly once per injection and holds otherwise, so identical seeds and schedules give identical target sequences.
- R6: The outcome window is `WIN` cycles long and starts in the strobe cycle. Only the first `res_valid` in the window counts. `res_code` 2'b01 means corrected, 2'b10 means detected only, and 2'b00 or 2'b11 means undetected. If there is no report by the last cycle of the window, the injection counts as undetected.
- R7: Every injection increments the total counter and the injection counter of its register. Every outcome increments its global class counter and that class counter of the injected register. A register can be hit more than once in a campaign.
- R8: `done` rises the cycle after the last entry's outcome is settled. With `sched_len` = 0, `done` rises the cycle after `start`. No strobe occurs while `done` is high, and `busy` is high only while a campaign runs.
- R9: `clr` zeroes all counters and drops `done`. A new `start` without `clr` adds to the existing counters.
- R10: `rd_data` shows, one cycle after `rd_sel`/`rd_reg` are applied, the counter selected as follows. `rd_sel` 0 is the total, 1 corrected, 2 detected only, 3 undetected. Values 4 to 7 read the same four counters for register `rd_reg`.
- R11: A `res_valid` that arrives outside an outcome window (while idle, or after the window's first report) changes no counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_we | input | 1 | Write one schedule entry |
| sched_waddr | input | $clog2(SCHED_DEPTH) | Schedule entry index |
| sched_wtime | input | TIME_W | Injection instant in campaign cycles |
| sched_len | input | $clog2(SCHED_DEPTH+1) | Number of entries in the campaign |
| seed_we | input | 1 | Load both generator seeds |
| seed_reg | input | LFSR_W | Seed of the register-select generator |
| seed_bit | input | LFSR_W | Seed of the bit-select generator |
| start | input | 1 | Begin a campaign |
| clr | input | 1 | Zero all counters, drop done |
| inj_stb | output | 1 | One-cycle injection strobe |
| inj_addr | output | $clog2(NUM_REGS) | Target register index |
| inj_mask | output | REG_W | One-hot inversion mask |
| res_valid | input | 1 | Outcome report valid |
| res_code | input | 2 | Outcome class code |
| rd_sel | input | 3 | Counter select |
| rd_reg | input | $clog2(NUM_REGS) | Register for per-register counters |
| rd_data | output | CNT_W | Selected counter value |
| busy | output | 1 | Campaign in progress |
| done | output | 1 | Schedule exhausted |

## Verification
Some properties hold on every cycle. The assertions check these continuously: the one-hot mask during a strobe and the zero mask otherwise, single-cycle strobes, an in-range target address, generators that never reach zero and that hold when no injection occurs, a bounded outcome window, a total counter that steps by at most one, zeroed counters after a clear, and no strobe while done. Other behaviour depends on data values and can only be shown by the bench scenarios. That includes the exact strobe cycle for each scheduled time, the target sequence implied by the seeds (including the replacement of a zero seed), reproducibility after reseeding, the mapping of outcome codes to classes, timeouts and ignored late reports, accumulation across campaigns, and an empty schedule.

// File: rtl/seu_pkg.sv
package seu_pkg;

  // counter index inside a tally group
  typedef enum logic [1:0] {
    K_INJ   = 2'd0,
    K_CORR  = 2'd1,
    K_DET   = 2'd2,
    K_UNDET = 2'd3
  } tally_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_WAIT,
    ST_DONE
  } state_t;

  function automatic tally_t classify(input logic [1:0] code);
    case (code)
      2'b01:   return K_CORR;
      2'b10:   return K_DET;
      default: return K_UNDET;
    endcase
  endfunction

endpackage

// File: rtl/seu_lfsr.sv
module seu_lfsr #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   TAPS = 'hD008
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         adv,
  output logic [W-1:0] value
);

  always_ff @(posedge clk) begin
    if (rst)
      value <= W'(1);
    else if (load)
      value <= (seed == '0) ? W'(1) : seed;
    else if (adv)
      value <= {value[W-2:0], ^(value & TAPS)};
  end

  // R2: zero seed replaced, so the register can never lock up at zero
  a_r2_never_zero: assert property (@(posedge clk) disable iff (rst)
    value != '0);

  // R5: the generator moves only on an injection or a seed load
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(value));

endmodule

// File: rtl/seu_sched_mem.sv
module seu_sched_mem #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int DW    = 20
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/seu_tally.sv
module seu_tally
  import seu_pkg::*;
#(
  parameter int NREG = 8,
  parameter int RAW  = 3,
  parameter int CW   = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           inc_inj,
  input  logic [RAW-1:0] inj_reg,
  input  logic           inc_out,
  input  logic [RAW-1:0] out_reg,
  input  tally_t         out_kind,
  input  logic [2:0]     rd_sel,
  input  logic [RAW-1:0] rd_reg,
  output logic [CW-1:0]  rd_data
);

  logic [CW-1:0] g_cnt [4];
  logic [CW-1:0] r_cnt [NREG][4];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int k = 0; k < 4; k++) g_cnt[k] <= '0;
      for (int r = 0; r < NREG; r++)
        for (int k = 0; k < 4; k++) r_cnt[r][k] <= '0;
    end else begin
      if (inc_inj) begin
        g_cnt[K_INJ]          <= g_cnt[K_INJ] + 1'b1;
        r_cnt[inj_reg][K_INJ] <= r_cnt[inj_reg][K_INJ] + 1'b1;
      end
      if (inc_out) begin
        g_cnt[out_kind]          <= g_cnt[out_kind] + 1'b1;
        r_cnt[out_reg][out_kind] <= r_cnt[out_reg][out_kind] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_sel[2])
      rd_data <= r_cnt[rd_reg][rd_sel[1:0]];
    else
      rd_data <= g_cnt[rd_sel[1:0]];
  end

  // R7: the campaign total grows by at most one per cycle
  a_r7_total_step: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (g_cnt[K_INJ] == $past(g_cnt[K_INJ]) ||
              g_cnt[K_INJ] == $past(g_cnt[K_INJ]) + CW'(1)));

  // R9: a clear leaves every global counter at zero
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr |=> (g_cnt[K_INJ] == '0 && g_cnt[K_CORR] == '0 &&
             g_cnt[K_DET] == '0 && g_cnt[K_UNDET] == '0));

endmodule

// File: rtl/seu_injector.sv
module seu_injector
  import seu_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int REG_W       = 16,
  parameter int SCHED_DEPTH = 16,
  parameter int TIME_W      = 20,
  parameter int CNT_W       = 16,
  parameter int WIN         = 8,
  parameter int LFSR_W      = 16,
  localparam int RAW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int BW  = (REG_W > 1) ? $clog2(REG_W) : 1,
  localparam int SAW = (SCHED_DEPTH > 1) ? $clog2(SCHED_DEPTH) : 1,
  localparam int SCW = $clog2(SCHED_DEPTH + 1),
  localparam int WCW = $clog2(WIN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sched_we,
  input  logic [SAW-1:0]    sched_waddr,
  input  logic [TIME_W-1:0] sched_wtime,
  input  logic [SCW-1:0]    sched_len,
  input  logic              seed_we,
  input  logic [LFSR_W-1:0] seed_reg,
  input  logic [LFSR_W-1:0] seed_bit,
  input  logic              start,
  input  logic              clr,
  output logic              inj_stb,
  output logic [RAW-1:0]    inj_addr,
  output logic [REG_W-1:0]  inj_mask,
  input  logic              res_valid,
  input  logic [1:0]        res_code,
  input  logic [2:0]        rd_sel,
  input  logic [RAW-1:0]    rd_reg,
  output logic [CNT_W-1:0]  rd_data,
  output logic              busy,
  output logic              done
);

  state_t            st;
  logic [TIME_W-1:0] tcnt;
  logic [TIME_W-1:0] sched_q;
  logic [SCW-1:0]    idx;
  logic [WCW-1:0]    wcnt;
  logic [LFSR_W-1:0] lfsr_r, lfsr_b;
  logic [RAW-1:0]    sel_reg;
  logic [BW-1:0]     sel_bit;
  logic              fire, resolve, last;

  seu_sched_mem #(.DEPTH(SCHED_DEPTH), .AW(SAW), .DW(TIME_W)) u_sched (
    .clk(clk), .we(sched_we), .waddr(sched_waddr), .wdata(sched_wtime),
    .raddr(idx[SAW-1:0]), .rdata(sched_q)
  );

  seu_lfsr #(.W(LFSR_W)) u_pick_reg (
    .clk(clk), .rst(rst), .load(seed_we), .seed(seed_reg), .adv(fire), .value(lfsr_r)
  );

  seu_lfsr #(.W(LFSR_W)) u_pick_bit (
    .clk(clk), .rst(rst), .load(seed_we), .seed(seed_bit), .adv(fire), .value(lfsr_b)
  );

  assign sel_reg = RAW'(lfsr_r % NUM_REGS);
  assign sel_bit = BW'(lfsr_b % REG_W);
  assign fire    = (st == ST_RUN) && !start && (tcnt == sched_q);
  assign resolve = (st == ST_WAIT) && !start && (res_valid || wcnt == WCW'(WIN - 1));
  assign last    = (idx == sched_len);
  assign busy    = (st == ST_LOAD) || (st == ST_RUN) || (st == ST_WAIT);
  assign done    = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      tcnt     <= '0;
      idx      <= '0;
      wcnt     <= '0;
      inj_stb  <= 1'b0;
      inj_addr <= '0;
      inj_mask <= '0;
    end else begin
      inj_stb  <= 1'b0;
      inj_mask <= '0;
      if (start) begin
        tcnt <= '0;
        idx  <= '0;
        st   <= (sched_len == '0) ? ST_DONE : ST_LOAD;
      end else if (clr && st == ST_DONE) begin
        st <= ST_IDLE;
      end else begin
        case (st)
          ST_LOAD: begin
            tcnt <= tcnt + 1'b1;
            st   <= ST_RUN;
          end
          ST_RUN: begin
            tcnt <= tcnt + 1'b1;
            if (fire) begin
              inj_stb  <= 1'b1;
              inj_addr <= sel_reg;
              inj_mask <= REG_W'(1) << sel_bit;
              idx      <= idx + 1'b1;
              wcnt     <= '0;
              st       <= ST_WAIT;
            end
          end
          ST_WAIT: begin
            tcnt <= tcnt + 1'b1;
            if (resolve)
              st <= last ? ST_DONE : ST_RUN;
            else
              wcnt <= wcnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  seu_tally #(.NREG(NUM_REGS), .RAW(RAW), .CW(CNT_W)) u_tally (
    .clk(clk), .rst(rst), .clr(clr),
    .inc_inj(inj_stb), .inj_reg(inj_addr),
    .inc_out(resolve), .out_reg(inj_addr),
    .out_kind(res_valid ? classify(res_code) : K_UNDET),
    .rd_sel(rd_sel), .rd_reg(rd_reg), .rd_data(rd_data)
  );

  // R4: exactly one bit set in the mask while striking
  a_r4_mask_onehot: assert property (@(posedge clk) disable iff (rst)
    inj_stb |-> $countones(inj_mask) == 1);

  // R4: mask quiet between strikes
  a_r4_mask_quiet: assert property (@(posedge clk) disable iff (rst)
    !inj_stb |-> inj_mask == '0);

  // R4: strobe never longer than a cycle
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
    inj_stb |=> !inj_stb);

  // R4: target index inside the bank
  a_r4_addr_range: assert property (@(posedge clk) disable iff (rst)
    inj_stb |-> int'(inj_addr) < NUM_REGS);

  // R3: a strike is launched only from the waiting-for-time state
  a_r3_from_run: assert property (@(posedge clk) disable iff (rst)
    inj_stb |-> $past(st) == ST_RUN);

  // R6: the outcome window never exceeds its length
  a_r6_window_bound: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |-> int'(wcnt) < WIN);

  // R8: no strike once the schedule is exhausted
  a_r8_quiet_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !inj_stb);

endmodule

// File: tb/sim_seu_injector.sv
`timescale 1ns/1ps
module sim_seu_injector;

  localparam int WIN = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sched_we = 1'b0;
  logic [3:0]  sched_waddr = '0;
  logic [19:0] sched_wtime = '0;
  logic [4:0]  sched_len = '0;
  logic        seed_we = 1'b0;
  logic [15:0] seed_reg = '0, seed_bit = '0;
  logic        start = 1'b0, clr = 1'b0;
  logic        inj_stb;
  logic [2:0]  inj_addr;
  logic [15:0] inj_mask;
  logic        res_valid = 1'b0;
  logic [1:0]  res_code = '0;
  logic [2:0]  rd_sel = '0;
  logic [2:0]  rd_reg = '0;
  logic [15:0] rd_data;
  logic        busy, done;

  always #2 clk = ~clk;

  seu_injector u0 (
    .clk(clk), .rst(rst), .sched_we(sched_we), .sched_waddr(sched_waddr),
    .sched_wtime(sched_wtime), .sched_len(sched_len), .seed_we(seed_we),
    .seed_reg(seed_reg), .seed_bit(seed_bit), .start(start), .clr(clr),
    .inj_stb(inj_stb), .inj_addr(inj_addr), .inj_mask(inj_mask),
    .res_valid(res_valid), .res_code(res_code), .rd_sel(rd_sel),
    .rd_reg(rd_reg), .rd_data(rd_data), .busy(busy), .done(done)
  );

  int n_chk = 0, n_err = 0;
  int m_g [4];
  int m_r [8][4];
  logic [15:0] ma, mb;
  int tbl [16];
  int seq_a [16];
  int seq_b [16];

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lf_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction

  function automatic int code_class(input logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b10) return 2;
    return 3;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 4; k++) begin
      m_g[k] = 0;
      for (int r = 0; r < 8; r++) m_r[r][k] = 0;
    end
  endtask

  task automatic load_seeds(input logic [15:0] a, input logic [15:0] b);
    seed_reg = a; seed_bit = b; seed_we = 1'b1;
    tick();
    seed_we = 1'b0;
    ma = (a == 16'h0) ? 16'h1 : a;   // R2 zero seed becomes 1
    mb = (b == 16'h0) ? 16'h1 : b;
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < 4; k++) begin
      rd_sel = 3'(k); tick();
      chk(rd_data == 16'(m_g[k]), {tag, " R10 global counter"}, int'(rd_data), m_g[k]);
    end
    for (int r = 0; r < 8; r++)
      for (int k = 0; k < 4; k++) begin
        rd_sel = 3'(4 + k); rd_reg = 3'(r); tick();
        chk(rd_data == 16'(m_r[r][k]), {tag, " R7 per-register counter"}, int'(rd_data), m_r[r][k]);
      end
  endtask

  task automatic do_clear();
    clr = 1'b1; tick(); clr = 1'b0;
    model_clear();
  endtask

  // runs one campaign over tbl[0..n-1]; rec selects which sequence record to fill
  task automatic run_camp(input int n, input int rec);
    int cyc, i, resp_at, deadline, cur, last_tally, code_v;
    bit pending, dbl;
    logic [15:0] emask;
    int ea, eb;
    for (int e = 0; e < n; e++) begin
      sched_we = 1'b1; sched_waddr = 4'(e); sched_wtime = 20'(tbl[e]);
      tick();
    end
    sched_we = 1'b0;
    sched_len = 5'(n);
    start = 1'b1; tick(); start = 1'b0;
    cyc = 0; i = 0; resp_at = -1; deadline = -1; pending = 0; dbl = 0;
    cur = 0; last_tally = -10; code_v = 0;
    while (cyc < 4000) begin
      if (done) break;
      if (i < n && cyc == tbl[i] + 1) begin
        chk(inj_stb == 1'b1, "R3 strobe at scheduled cycle", int'(inj_stb), 1);
        ea = int'(ma % 16'd8);
        eb = int'(mb % 16'd16);
        emask = 16'h1 << eb;
        chk(inj_addr == 3'(ea), "R4 target register", int'(inj_addr), ea);
        chk(inj_mask == emask, "R4 bit mask", int'(inj_mask), int'(emask));
        if (rec == 1) seq_a[i] = ea;
        if (rec == 2) seq_b[i] = ea;
        ma = lf_next(ma); mb = lf_next(mb);
        m_g[0]++; m_r[ea][0]++;
        cur = ea; i++;
        pending = 1; deadline = cyc + WIN - 1;
        if ($urandom % 10 < 7) begin
          resp_at = cyc + int'($urandom % WIN);
          code_v = int'($urandom % 4);
          dbl = ($urandom % 3 == 0);
        end else begin
          resp_at = -1; dbl = 0;
        end
      end else if (inj_stb) begin
        chk(1'b0, "R3 unexpected strobe", int'(inj_stb), 0);
      end
      res_valid = 1'b0; res_code = 2'b00;
      if (resp_at >= 0 && cyc == resp_at) begin
        res_valid = 1'b1; res_code = 2'(code_v);
      end else if (dbl && resp_at >= 0 && cyc == resp_at + 1) begin
        res_valid = 1'b1; res_code = 2'b01;   // R11 late report must be ignored
      end
      if (pending && resp_at >= 0 && cyc == resp_at) begin
        m_g[code_class(2'(code_v))]++; m_r[cur][code_class(2'(code_v))]++;
        pending = 0; last_tally = cyc;
      end else if (pending && resp_at < 0 && cyc == deadline) begin
        m_g[3]++; m_r[cur][3]++;        // R6 timeout counts as undetected
        pending = 0; last_tally = cyc;
      end
      tick(); cyc++;
    end
    res_valid = 1'b0;
    chk(i == n, "R8 injection count before done", i, n);
    chk(done == 1'b1, "R8 done after schedule", int'(done), 1);
    chk(cyc == last_tally + 1, "R8 done timing", cyc, last_tally + 1);
    chk(busy == 1'b0, "R8 busy low when done", int'(busy), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int mx;
    void'($urandom(32'h5EED));
    model_clear();
    ma = 16'h1; mb = 16'h1;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    chk(inj_stb == 1'b0, "R1 strobe low", int'(inj_stb), 0);
    chk(inj_mask == 16'h0, "R1 mask zero", int'(inj_mask), 0);
    chk(done == 1'b0, "R1 done low", int'(done), 0);
    chk(busy == 1'b0, "R1 busy low", int'(busy), 0);
    check_all("R1");

    // R11 reports while idle change nothing
    res_valid = 1'b1; res_code = 2'b01;
    repeat (4) tick();
    res_code = 2'b11;
    repeat (2) tick();
    res_valid = 1'b0;
    check_all("R11");

    // directed: earliest time, minimum spacing
    load_seeds(16'hACE1, 16'h1234);
    tbl[0] = 1;
    for (int e = 1; e < 6; e++) tbl[e] = tbl[e-1] + WIN + 1;
    run_camp(6, 1);
    check_all("R6");

    // R2 zero seeds behave as 1; R9 counters accumulate without clear
    load_seeds(16'h0000, 16'h0000);
    tbl[0] = 3;
    for (int e = 1; e < 8; e++) tbl[e] = tbl[e-1] + WIN + 2 + int'($urandom % 5);
    run_camp(8, 0);
    check_all("R2 R9 accumulate");

    // R9 clear
    do_clear();
    chk(done == 1'b0, "R9 done dropped by clear", int'(done), 0);
    check_all("R9 cleared");

    // R5 reproducibility with the same seeds and schedule
    load_seeds(16'hACE1, 16'h1234);
    tbl[0] = 1;
    for (int e = 1; e < 6; e++) tbl[e] = tbl[e-1] + WIN + 1;
    run_camp(6, 2);
    for (int e = 0; e < 6; e++)
      chk(seq_a[e] == seq_b[e], "R5 repeated target sequence", seq_b[e], seq_a[e]);
    check_all("R5");

    // R8 empty schedule
    sched_len = 5'd0;
    start = 1'b1; tick(); start = 1'b0;
    chk(done == 1'b1, "R8 empty schedule done", int'(done), 1);
    chk(inj_stb == 1'b0, "R8 no strobe for empty schedule", int'(inj_stb), 0);
    tick();
    chk(inj_stb == 1'b0, "R8 still no strobe", int'(inj_stb), 0);
    do_clear();

    // random campaigns filling the whole schedule
    for (int c = 0; c < 4; c++) begin
      load_seeds(16'($urandom), 16'($urandom));
      tbl[0] = 1 + int'($urandom % 6);
      for (int e = 1; e < 16; e++) tbl[e] = tbl[e-1] + WIN + 1 + int'($urandom % 20);
      run_camp(16, 0);
      mx = 0;
      for (int r = 0; r < 8; r++) if (m_r[r][0] > mx) mx = m_r[r][0];
      chk(mx >= 2, "R7 register hit more than once", mx, 2);
      check_all("R7 random");
    end

    finish_run();
  end

endmodule